// File: doc/BRIEF.md
# Sandbox Memory Access Checker

This block guards a banked memory against DMA requests issued by eight vector coprocessors. A request names the coprocessor that issued it, whether it reads or writes, and a 16-bit block address. Every address names one 1024-bit block, so there are no byte or word bits below it. The upper three address bits pick one of eight banks, and the lower thirteen bits pick a block inside that bank.

Before any bank is touched, the checker searches an on-chip table of sandboxes for the entry whose inclusive address range covers the request. Each entry holds an 8-bit mask with one bit per coprocessor. If that bit is set, the request is passed to the chosen bank's controller as a grant. Otherwise it is refused: a deny pulse names the offender and a violation counter steps up.

The table is plain registers. It is never evicted, so every verdict takes the same single cycle. A configuration port rewrites one entry at a time.

Top module: `sbx_guard`

## Requirements
- R1: A granted request presents bank = address bits [15:13] and block = address bits [12:0] on the grant outputs, together with the request's read/write flag (1 = write) and requester ID.
- R2: Entry k covers an address when base <= address <= limit, with both bounds inclusive. There are 16 entries, indexed 0 to 15.
- R3: When the deciding entry's mask bit [requester ID] is 1, the request is granted. When that bit is 0, the request is denied.
- R4: An address that no entry covers is denied. After reset every entry has base 0, limit 0 and mask 0, so every request is denied until the table is loaded.
- R5: When several entries cover an address, the entry with the lowest index decides the verdict.
- R6: One cycle after a request is accepted (req_valid and req_ready both high at a clock edge), exactly one of grant_valid and deny_valid pulses for one cycle. With no acceptance, neither pulses.
- R7: A deny pulse carries the requester ID on deny_id. viol_count increases by one for each deny and saturates at all ones.
- R8: A table write made at a clock edge applies to requests accepted from the next edge on. A request accepted at the same edge as the write is judged against the old entry.
- R9: While reset is high, req_ready, grant_valid and deny_valid are 0 and viol_count is 0. req_ready rises one cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | 4 | Index of the entry written |
| cfg_base | input | 16 | Lowest block address covered |
| cfg_limit | input | 16 | Highest block address covered |
| cfg_mask | input | 8 | Permitted requesters, bit n = requester n |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Checker accepts requests |
| req_id | input | 3 | Requester ID |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Block address {bank, block} |
| grant_valid | output | 1 | Request forwarded to a bank |
| grant_bank | output | 3 | Target bank |
| grant_blk | output | 13 | Block within the bank |
| grant_wr | output | 1 | Forwarded read/write flag |
| grant_id | output | 3 | Forwarded requester ID |
| deny_valid | output | 1 | Request refused |
| deny_id | output | 3 | ID of the refused requester |
| viol_count | output | 16 | Number of refusals, saturating |

## Verification
The assertions assume that req_id, req_wr and req_addr are stable and known whenever req_valid is high at an edge. They also assume that cfg_idx and the cfg fields are known whenever cfg_we is high. The bench changes every input only on the falling edge and never leaves an undefined value on them. It holds reset for several cycles, so no clocked property ever samples the pre-reset state. Table writes land in the same cycle as requests only in the deliberate R8 case, and the bench's model applies each write after judging that cycle's request.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
    localparam int NUM_REQ  = 8;
    localparam int ID_W     = $clog2(NUM_REQ);
    localparam int NUM_BANK = 8;
    localparam int BANK_W   = $clog2(NUM_BANK);
    localparam int BLK_W    = 13;
    localparam int ADDR_W   = BANK_W + BLK_W;
    localparam int NUM_ENT  = 16;
    localparam int CNT_W    = 16;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [ID_W-1:0]    rid_t;
    typedef logic [NUM_REQ-1:0] rmask_t;

    typedef struct packed {
        addr_t  base;
        addr_t  limit;
        rmask_t allow;
    } sbx_entry_t;

    typedef struct packed {
        rid_t  id;
        logic  wr;
        addr_t addr;
    } dma_req_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [BLK_W-1:0]  blk;
        logic              wr;
        rid_t              id;
    } grant_t;

    function automatic logic covers(addr_t a, sbx_entry_t e);
        return (a >= e.base) && (a <= e.limit);
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(addr_t a);
        return a[ADDR_W-1 -: BANK_W];
    endfunction

    function automatic logic [BLK_W-1:0] blk_of(addr_t a);
        return a[BLK_W-1:0];
    endfunction
endpackage

// File: rtl/sbx_table.sv
module sbx_table
    import sbx_pkg::*;
#(
    parameter int N_ENT = NUM_ENT,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  sbx_entry_t                   wr_entry,
    output sbx_entry_t [N_ENT-1:0]       tbl_o
);
    sbx_entry_t [N_ENT-1:0] tbl_q;

    generate
        for (genvar k = 0; k < N_ENT; k++) begin : g_ent
            always_ff @(posedge clk) begin
                if (rst) begin
                    tbl_q[k] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(k))) begin
                    tbl_q[k] <= wr_entry;
                end
            end
        end
    endgenerate

    assign tbl_o = tbl_q;
endmodule

// File: rtl/sbx_match.sv
module sbx_match
    import sbx_pkg::*;
#(
    parameter int N_ENT = NUM_ENT,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  sbx_entry_t [N_ENT-1:0] tbl_i,
    input  dma_req_t               req_i,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       sel_o,
    output logic                   permit_o
);
    logic [N_ENT-1:0] hit_vec;

    generate
        for (genvar k = 0; k < N_ENT; k++) begin : g_cmp
            assign hit_vec[k] = covers(req_i.addr, tbl_i[k]);
        end
    endgenerate

    // scan from the top down so the lowest covering index wins
    always_comb begin
        sel_o = '0;
        for (int k = N_ENT - 1; k >= 0; k--) begin
            if (hit_vec[k]) sel_o = IDX_W'(k);
        end
    end

    assign hit_o    = |hit_vec;
    assign permit_o = hit_o && tbl_i[sel_o].allow[req_i.id];
endmodule

// File: rtl/sbx_verdict.sv
module sbx_verdict
    import sbx_pkg::*;
#(
    parameter int C_W = CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           accept,
    input  logic           permit,
    input  dma_req_t       req_i,
    output logic           grant_valid,
    output grant_t         grant_o,
    output logic           deny_valid,
    output rid_t           deny_id,
    output logic [C_W-1:0] viol_count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_valid <= 1'b0;
            deny_valid  <= 1'b0;
            grant_o     <= '0;
            deny_id     <= '0;
            viol_count  <= '0;
        end else begin
            grant_valid <= accept && permit;
            deny_valid  <= accept && !permit;
            if (accept && permit) begin
                grant_o.bank <= bank_of(req_i.addr);
                grant_o.blk  <= blk_of(req_i.addr);
                grant_o.wr   <= req_i.wr;
                grant_o.id   <= req_i.id;
            end
            if (accept && !permit) begin
                deny_id <= req_i.id;
                if (viol_count != {C_W{1'b1}}) viol_count <= viol_count + 1'b1;
            end
        end
    end

    // R6: one verdict per acceptance, never two at once
    a_r6_one_verdict: assert property (@(posedge clk) disable iff (rst)
        accept |=> (grant_valid ^ deny_valid));
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !accept |=> (!grant_valid && !deny_valid));
    // R1: forwarded bank and block come from the accepted address
    a_r1_route: assert property (@(posedge clk) disable iff (rst)
        (accept && permit) |=> (grant_o.bank == $past(req_i.addr[ADDR_W-1 -: BANK_W])
                                && grant_o.blk == $past(req_i.addr[BLK_W-1:0])));
    // R7: deny names the requester, counter moves only on deny
    a_r7_deny_id: assert property (@(posedge clk) disable iff (rst)
        deny_valid |-> (deny_id == $past(req_i.id)));
    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        (deny_valid && $past(viol_count) != {C_W{1'b1}}) |-> (viol_count == $past(viol_count) + 1'b1));
    a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
        !deny_valid |-> $stable(viol_count));
endmodule

// File: rtl/sbx_guard.sv
module sbx_guard
    import sbx_pkg::*;
#(
    parameter int N_ENT = NUM_ENT,
    parameter int C_W   = CNT_W,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic [ADDR_W-1:0]     cfg_limit,
    input  logic [NUM_REQ-1:0]    cfg_mask,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ID_W-1:0]       req_id,
    input  logic                  req_wr,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic                  grant_valid,
    output logic [BANK_W-1:0]     grant_bank,
    output logic [BLK_W-1:0]      grant_blk,
    output logic                  grant_wr,
    output logic [ID_W-1:0]       grant_id,
    output logic                  deny_valid,
    output logic [ID_W-1:0]       deny_id,
    output logic [C_W-1:0]        viol_count
);
    sbx_entry_t [N_ENT-1:0] tbl;
    sbx_entry_t             new_entry;
    dma_req_t               req;
    grant_t                 gnt;
    logic                   ready_q;
    logic                   accept;
    logic                   m_hit;
    logic                   m_permit;
    logic [IDX_W-1:0]       m_sel;

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= 1'b1;
    end

    assign req_ready = ready_q;
    assign accept    = req_valid && ready_q;

    assign new_entry = '{base: cfg_base, limit: cfg_limit, allow: cfg_mask};
    assign req       = '{id: req_id, wr: req_wr, addr: req_addr};

    sbx_table #(.N_ENT(N_ENT)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_entry (new_entry),
        .tbl_o    (tbl)
    );

    sbx_match #(.N_ENT(N_ENT)) u_match (
        .tbl_i    (tbl),
        .req_i    (req),
        .hit_o    (m_hit),
        .sel_o    (m_sel),
        .permit_o (m_permit)
    );

    sbx_verdict #(.C_W(C_W)) u_verdict (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .permit      (m_permit),
        .req_i       (req),
        .grant_valid (grant_valid),
        .grant_o     (gnt),
        .deny_valid  (deny_valid),
        .deny_id     (deny_id),
        .viol_count  (viol_count)
    );

    assign grant_bank = gnt.bank;
    assign grant_blk  = gnt.blk;
    assign grant_wr   = gnt.wr;
    assign grant_id   = gnt.id;

    // R4: an address outside every sandbox is always refused
    a_r4_uncovered_denied: assert property (@(posedge clk) disable iff (rst)
        (accept && !m_hit) |=> deny_valid);
    // R3: the deciding entry's mask bit gates the grant
    a_r3_mask_gates: assert property (@(posedge clk) disable iff (rst)
        (accept && m_hit && !tbl[m_sel].allow[req_id]) |=> deny_valid);
    // R6: at most one verdict outstanding
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(grant_valid && deny_valid));
endmodule

// File: tb/sbx_guard_test.sv
module sbx_guard_test;
    import sbx_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [15:0] cfg_base = '0;
    logic [15:0] cfg_limit = '0;
    logic [7:0]  cfg_mask = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_id = '0;
    logic        req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic        grant_valid;
    logic [2:0]  grant_bank;
    logic [12:0] grant_blk;
    logic        grant_wr;
    logic [2:0]  grant_id;
    logic        deny_valid;
    logic [2:0]  deny_id;
    logic [15:0] viol_count;

    always #5 clk = ~clk;

    sbx_guard uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_mask(cfg_mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
        .req_wr(req_wr), .req_addr(req_addr), .grant_valid(grant_valid),
        .grant_bank(grant_bank), .grant_blk(grant_blk), .grant_wr(grant_wr),
        .grant_id(grant_id), .deny_valid(deny_valid), .deny_id(deny_id),
        .viol_count(viol_count)
    );

    typedef struct packed {
        logic        v;
        logic        g;
        logic [2:0]  bank;
        logic [12:0] blk;
        logic        wr;
        logic [2:0]  id;
        logic [15:0] cnt;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    logic [15:0] m_base [16];
    logic [15:0] m_limit[16];
    logic [7:0]  m_mask [16];
    logic [15:0] m_cnt = '0;

    task automatic fail(string tag, string what, int act, int expv);
        fails++;
        $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    endtask

    // driver: applies one cycle of stimulus and queues what must follow
    task automatic step(bit we, int widx, logic [15:0] b, logic [15:0] l, logic [7:0] m,
                        bit v, logic [2:0] id, bit wr, logic [15:0] a, string tag);
        exp_t e;
        int   dec;
        @(negedge clk);
        cfg_we = we; cfg_idx = 4'(widx); cfg_base = b; cfg_limit = l; cfg_mask = m;
        req_valid = v; req_id = id; req_wr = wr; req_addr = a;
        dec = -1;
        for (int k = 15; k >= 0; k--)
            if (a >= m_base[k] && a <= m_limit[k]) dec = k;
        e.v = v;
        e.g = v && dec >= 0 && m_mask[dec][id];
        e.bank = a[15:13];
        e.blk = a[12:0];
        e.wr = wr;
        e.id = id;
        if (v && !e.g) m_cnt = m_cnt + 1;
        e.cnt = m_cnt;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (we) begin
            m_base[widx] = b; m_limit[widx] = l; m_mask[widx] = m;
        end
    endtask

    task automatic cfg(int idx, logic [15:0] b, logic [15:0] l, logic [7:0] m);
        step(1'b1, idx, b, l, m, 1'b0, 3'd0, 1'b0, 16'h0, "R8 cfg");
    endtask

    task automatic rq(logic [2:0] id, bit wr, logic [15:0] a, string tag);
        step(1'b0, 0, 16'h0, 16'h0, 8'h0, 1'b1, id, wr, a, tag);
    endtask

    // monitor: compares each cycle's outputs with the queued expectation
    initial begin
        forever begin
            exp_t  e;
            string t;
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (!e.v) begin
                    if (grant_valid || deny_valid) fail(t, "idle verdict", {grant_valid, deny_valid}, 0);
                end else if (e.g) begin
                    if (!grant_valid || deny_valid) fail(t, "grant/deny", {grant_valid, deny_valid}, 2);
                    else if (grant_bank != e.bank) fail(t, "bank", grant_bank, e.bank);
                    else if (grant_blk != e.blk) fail(t, "block", grant_blk, e.blk);
                    else if (grant_wr != e.wr) fail(t, "wr", grant_wr, e.wr);
                    else if (grant_id != e.id) fail(t, "id", grant_id, e.id);
                end else begin
                    if (grant_valid || !deny_valid) fail(t, "grant/deny", {grant_valid, deny_valid}, 1);
                    else if (deny_id != e.id) fail(t, "deny_id", deny_id, e.id);
                end
                if (viol_count != e.cnt) fail({t, " R7"}, "viol_count", viol_count, e.cnt);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R6: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) begin
            m_base[k] = '0; m_limit[k] = '0; m_mask[k] = '0;
        end
        repeat (4) @(negedge clk);
        // R9 reset state
        checks++;
        if (req_ready || grant_valid || deny_valid || viol_count != 0)
            fail("R9", "reset outputs", {req_ready, grant_valid, deny_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (!req_ready) fail("R9", "ready after reset", req_ready, 1);

        // R4: empty table refuses everything
        rq(3'd0, 1'b0, 16'h2000, "R4 empty table");
        rq(3'd5, 1'b1, 16'h0000, "R4 zero entry");
        // R2/R3 sandbox 0x2000..0x3FFF for requesters 0 and 2
        cfg(3, 16'h2000, 16'h3FFF, 8'b0000_0101);
        rq(3'd0, 1'b0, 16'h2000, "R1 R2 low bound grant");
        rq(3'd2, 1'b1, 16'h3FFF, "R1 R2 high bound grant");
        rq(3'd1, 1'b0, 16'h2800, "R3 mask denies");
        rq(3'd0, 1'b0, 16'h4000, "R2 above limit");
        rq(3'd0, 1'b0, 16'h1FFF, "R2 below base");
        step(1'b0, 0, 16'h0, 16'h0, 8'h0, 1'b0, 3'd0, 1'b0, 16'h2000, "R6 idle");
        // R5 overlap: entry 1 inside entry 3
        cfg(1, 16'h3000, 16'h3100, 8'b0000_0010);
        rq(3'd1, 1'b1, 16'h3050, "R5 lower entry grants");
        rq(3'd0, 1'b0, 16'h3050, "R5 lower entry denies");
        rq(3'd0, 1'b0, 16'h3101, "R5 outside overlap");
        cfg(5, 16'hE000, 16'hFFFF, 8'h80);
        rq(3'd7, 1'b1, 16'hFFFF, "R1 top bank");
        rq(3'd6, 1'b0, 16'hE123, "R3 top bank deny");
        // R8: same-edge write sees old contents, next edge sees new
        step(1'b1, 3, 16'h2000, 16'h3FFF, 8'hFF, 1'b1, 3'd1, 1'b0, 16'h2800, "R8 same edge old");
        rq(3'd1, 1'b0, 16'h2800, "R8 next edge new");
        step(1'b1, 3, 16'h2000, 16'h3FFF, 8'h00, 1'b0, 3'd0, 1'b0, 16'h0, "R8 revoke");
        rq(3'd1, 1'b0, 16'h2800, "R8 revoked");
        rq(3'd4, 1'b1, 16'h2801, "R7 back to back deny");
        step(1'b0, 0, 16'h0, 16'h0, 8'h0, 1'b0, 3'd0, 1'b0, 16'h0, "R6 idle end");
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule